// File: doc/BRIEF.md
# Rotating Tiled Framebuffer Address Generator

This block turns a stream of scaled pixels, arriving in raster order, into byte addresses in a destination framebuffer. It keeps its own source column and row counters and advances them once for each valid pixel. It maps each source position through one of four clockwise rotations. It then lays out the rotated position either as a plain linear raster or as 8x8 tiles suited to a graphics engine. Finally it scales the pixel index by the pixel size and adds a base address.

The frame geometry is programmed as width-minus-one and height-minus-one. For quarter-turn rotations the destination buffer has width and height exchanged. An illegal setup raises a configuration error, and while it is raised no addresses are issued and the counters hold their values. One illegal setup is a tiled layout whose dimensions are not multiples of 8, and another is an unsupported pixel size. The last pixel of a frame is marked with an end-of-frame pulse, and the counters then return to the origin.

Top module: `fb_rot_addr_gen`

## Requirements
- R1: On each accepted pixel the source column advances. Past the last column it returns to 0 and the row advances. After the last pixel of the frame both return to 0.
- R2: Each accepted pixel yields exactly one `addr_valid` pulse on the clock edge that accepts it. `addr_valid` stays low in cycles with no accepted pixel.
- R3: With W = `cfg_w_m1`+1 and H = `cfg_h_m1`+1, rotation code 0 maps source (x,y) to destination (x,y) in a W-wide buffer. Code 1 (90° clockwise) maps it to (H-1-y, x) in an H-wide buffer. Code 2 (180°) maps it to (W-1-x, H-1-y) in a W-wide buffer. Code 3 (270° clockwise) maps it to (y, W-1-x) in an H-wide buffer.
- R4: With `cfg_tile`=0 the pixel index is dy*DW+dx, where DW is the destination width.
- R5: With `cfg_tile`=1 the pixel index is ((dy/8)*(DW/8)+dx/8)*64 + (dy%8)*8 + dx%8.
- R6: `addr_out` equals `cfg_base` plus the pixel index times `cfg_bpp`. The legal values of `cfg_bpp` are 2, 3 and 4.
- R7: `cfg_err` is high whenever any of the following holds, and low otherwise: `cfg_tile`=1 with W or H not a multiple of 8; `cfg_bpp` outside 2..4; `cfg_h_m1` above 511.
- R8: While `cfg_err` is high, `pix_valid` is ignored. No address is issued, and the counters keep their position.
- R9: `eof` is high together with `addr_valid` for the last pixel of the frame (x=W-1, y=H-1) and low for every other pixel.
- R10: After reset `addr_valid` and `eof` are low and the first pixel maps to source (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_w_m1 | input | 9 | Frame width minus one |
| cfg_h_m1 | input | 10 | Frame height minus one |
| cfg_rot | input | 2 | Rotation code 0..3 |
| cfg_tile | input | 1 | Selects the 8x8 tiled layout |
| cfg_base | input | 32 | Destination base byte address |
| cfg_bpp | input | 3 | Bytes per pixel |
| pix_valid | input | 1 | One pixel arrives this cycle |
| addr_valid | output | 1 | `addr_out` holds a new address |
| addr_out | output | 32 | Byte address of the pixel |
| eof | output | 1 | Address belongs to the frame's last pixel |
| cfg_err | output | 1 | Current configuration is illegal |

## Verification
The bench runs non-square frames under every rotation code. A design that mixes up which buffer width applies after a quarter turn, or that mirrors instead of rotating at 180°, would give wrong addresses from the second row on. Tiled frames wider than one tile catch errors in the tile stride and in the ordering inside a tile. A frame is broken off mid-way by an illegal pixel size and then resumed with idle gaps between pixels. A block that counts or emits during the error would lose its place, and the addresses after the resume would be wrong. Separate frames test a single 512-pixel row and a single 1x1 pixel, where the column wrap and end-of-frame happen at once, and a 3-byte pixel size.

// File: rtl/fbag_pkg.sv
package fbag_pkg;

    typedef enum logic [1:0] {
        ROT_0   = 2'd0,
        ROT_90  = 2'd1,
        ROT_180 = 2'd2,
        ROT_270 = 2'd3
    } rot_e;

    localparam int TILE_LOG2 = 3;

    function automatic logic bpp_legal(input logic [2:0] bpp);
        return (bpp == 3'd2) || (bpp == 3'd3) || (bpp == 3'd4);
    endfunction

endpackage

// File: rtl/fbag_raster_ctr.sv
module fbag_raster_ctr #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [CW-1:0] x_last,
    input  logic [CW-1:0] y_last,
    output logic [CW-1:0] x,
    output logic [CW-1:0] y,
    output logic          last
);

    typedef struct packed {
        logic [CW-1:0] x;
        logic [CW-1:0] y;
    } ctr_t;

    ctr_t st_d, st_q;
    logic x_end, y_end;

    always_comb begin
        x_end = (st_q.x == x_last);
        y_end = (st_q.y == y_last);
        st_d  = st_q;
        if (adv) begin
            if (x_end) begin
                st_d.x = '0;
                st_d.y = y_end ? '0 : st_q.y + 1'b1;
            end else begin
                st_d.x = st_q.x + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x    = st_q.x;
    assign y    = st_q.y;
    assign last = x_end && y_end;

    // R1: after the frame's last pixel the counters return to the origin
    a_r1_wrap_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last) |=> (st_q.x == '0 && st_q.y == '0));

    // R8: without an advance the position is held
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(st_q.x) && $stable(st_q.y)));

endmodule

// File: rtl/fbag_rot_map.sv
module fbag_rot_map
    import fbag_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic [CW-1:0] sx,
    input  logic [CW-1:0] sy,
    input  logic [CW-1:0] w_m1,
    input  logic [CW-1:0] h_m1,
    input  logic [1:0]    rot,
    output logic [CW-1:0] dx,
    output logic [CW-1:0] dy,
    output logic [CW:0]   dw
);

    logic [CW:0] w_full, h_full;

    always_comb begin
        w_full = {1'b0, w_m1} + 1'b1;
        h_full = {1'b0, h_m1} + 1'b1;
        unique case (rot_e'(rot))
            ROT_0: begin
                dx = sx;
                dy = sy;
                dw = w_full;
            end
            ROT_90: begin
                dx = h_m1 - sy;
                dy = sx;
                dw = h_full;
            end
            ROT_180: begin
                dx = w_m1 - sx;
                dy = h_m1 - sy;
                dw = w_full;
            end
            default: begin
                dx = sy;
                dy = w_m1 - sx;
                dw = h_full;
            end
        endcase
    end

endmodule

// File: rtl/fbag_layout_idx.sv
module fbag_layout_idx
    import fbag_pkg::*;
#(
    parameter int CW    = 10,
    parameter int IDX_W = 20
) (
    input  logic [CW-1:0]    dx,
    input  logic [CW-1:0]    dy,
    input  logic [CW:0]      dw,
    input  logic             tile,
    output logic [IDX_W-1:0] idx
);

    localparam int PW = 2 * CW + 2;

    logic [PW-1:0] lin_prod;
    logic [PW-1:0] tile_row;
    logic [PW-1:0] tile_num;
    logic [PW-1:0] tile_idx;
    logic [PW-1:0] sel;

    always_comb begin
        lin_prod = {{(CW+1){1'b0}}, dy} * {{CW{1'b0}}, 1'b0, dw};
        lin_prod = lin_prod + {{(CW+2){1'b0}}, dx};

        tile_row = {{(CW+2){1'b0}}, dy >> TILE_LOG2}
                 * {{(CW+1){1'b0}}, dw >> TILE_LOG2};
        tile_num = tile_row + {{(CW+2){1'b0}}, dx >> TILE_LOG2};
        tile_idx = (tile_num << (2 * TILE_LOG2))
                 | {{(PW-6){1'b0}}, dy[2:0], dx[2:0]};

        sel = tile ? tile_idx : lin_prod;
        idx = sel[IDX_W-1:0];
    end

endmodule

// File: rtl/fb_rot_addr_gen.sv
module fb_rot_addr_gen
    import fbag_pkg::*;
#(
    parameter int WF     = 9,
    parameter int HF     = 10,
    parameter int ADDR_W = 32,
    parameter int BPP_W  = 3,
    parameter int MAX_DIM = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WF-1:0]     cfg_w_m1,
    input  logic [HF-1:0]     cfg_h_m1,
    input  logic [1:0]        cfg_rot,
    input  logic              cfg_tile,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [BPP_W-1:0]  cfg_bpp,
    input  logic              pix_valid,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr_out,
    output logic              eof,
    output logic              cfg_err
);

    localparam int CW    = (WF > HF) ? WF : HF;
    localparam int IDX_W = 2 * CW;
    localparam logic [HF-1:0] H_M1_MAX = HF'(MAX_DIM - 1);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic              eof;
    } out_t;

    out_t o_d, o_q;

    logic [CW-1:0]    w_m1_x, h_m1_x;
    logic [CW-1:0]    sx, sy, dx, dy;
    logic [CW:0]      dw;
    logic             at_last;
    logic             accept;
    logic             err;
    logic [IDX_W-1:0] idx;
    logic [ADDR_W-1:0] offs;

    assign w_m1_x = CW'(cfg_w_m1);
    assign h_m1_x = CW'(cfg_h_m1);

    always_comb begin
        err = 1'b0;
        if (cfg_tile && ((cfg_w_m1[2:0] != 3'b111) || (cfg_h_m1[2:0] != 3'b111)))
            err = 1'b1;
        if (!bpp_legal(cfg_bpp))
            err = 1'b1;
        if (cfg_h_m1 > H_M1_MAX)
            err = 1'b1;
    end

    assign accept = pix_valid && !err;

    fbag_raster_ctr #(.CW(CW)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (accept),
        .x_last (w_m1_x),
        .y_last (h_m1_x),
        .x      (sx),
        .y      (sy),
        .last   (at_last)
    );

    fbag_rot_map #(.CW(CW)) u_rot (
        .sx   (sx),
        .sy   (sy),
        .w_m1 (w_m1_x),
        .h_m1 (h_m1_x),
        .rot  (cfg_rot),
        .dx   (dx),
        .dy   (dy),
        .dw   (dw)
    );

    fbag_layout_idx #(.CW(CW), .IDX_W(IDX_W)) u_idx (
        .dx   (dx),
        .dy   (dy),
        .dw   (dw),
        .tile (cfg_tile),
        .idx  (idx)
    );

    always_comb begin
        offs      = ADDR_W'(idx) * ADDR_W'(cfg_bpp);
        o_d.vld   = accept;
        o_d.eof   = accept && at_last;
        o_d.addr  = accept ? (cfg_base + offs) : o_q.addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign addr_valid = o_q.vld;
    assign addr_out   = o_q.addr;
    assign eof        = o_q.eof;
    assign cfg_err    = err;

    // R8: a flagged configuration issues no address on the next edge
    a_r8_no_addr_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> !addr_valid);

    // R2: a legal pixel always yields an address
    a_r2_addr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !cfg_err) |=> addr_valid);

    // R2: no address appears without a pixel
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !addr_valid);

    // R9: end of frame only accompanies an issued address
    a_r9_eof_with_addr: assert property (@(posedge clk) disable iff (!rst_n)
        eof |-> addr_valid);

endmodule

// File: tb/fb_rot_addr_gen_tb.sv
module fb_rot_addr_gen_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  cfg_w_m1 = '0;
    logic [9:0]  cfg_h_m1 = '0;
    logic [1:0]  cfg_rot = '0;
    logic        cfg_tile = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [2:0]  cfg_bpp = 3'd4;
    logic        pix_valid = 1'b0;
    logic        addr_valid;
    logic [31:0] addr_out;
    logic        eof;
    logic        cfg_err;

    int n_tests = 0;
    int n_fail  = 0;
    logic [32:0] exp_q[$];
    logic [31:0] exp_tag[$];
    bit quiet_chk = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fb_rot_addr_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_w_m1   (cfg_w_m1),
        .cfg_h_m1   (cfg_h_m1),
        .cfg_rot    (cfg_rot),
        .cfg_tile   (cfg_tile),
        .cfg_base   (cfg_base),
        .cfg_bpp    (cfg_bpp),
        .pix_valid  (pix_valid),
        .addr_valid (addr_valid),
        .addr_out   (addr_out),
        .eof        (eof),
        .cfg_err    (cfg_err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected address from R3..R6
    function automatic logic [31:0] model_addr(int x, int y, int w, int h, int rot,
                                               bit tile, logic [31:0] base, int bpp);
        int dx, dy, dwid, idx;
        case (rot)
            0: begin dx = x;         dy = y;         dwid = w; end
            1: begin dx = h - 1 - y; dy = x;         dwid = h; end
            2: begin dx = w - 1 - x; dy = h - 1 - y; dwid = w; end
            default: begin dx = y;   dy = w - 1 - x; dwid = h; end
        endcase
        if (tile)
            idx = ((dy / 8) * (dwid / 8) + dx / 8) * 64 + (dy % 8) * 8 + (dx % 8);
        else
            idx = dy * dwid + dx;
        return base + 32'(idx * bpp);
    endfunction

    // Monitor: pops expected items as addresses appear
    always @(negedge clk) begin
        if (rst_n && addr_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected address", longint'(addr_out), 0);
            end else begin
                logic [32:0] e;
                logic [31:0] t;
                e = exp_q.pop_front();
                t = exp_tag.pop_front();
                check(addr_out == e[31:0], $sformatf("R3/R4/R5/R6 addr item %0d", t),
                      longint'(addr_out), longint'(e[31:0]));
                check(eof == e[32], $sformatf("R9 eof item %0d", t),
                      longint'(eof), longint'(e[32]));
            end
        end
    end

    task automatic set_cfg(int w, int h, int rot, bit tile, logic [31:0] base, int bpp);
        cfg_w_m1 = 9'(w - 1);
        cfg_h_m1 = 10'(h - 1);
        cfg_rot  = 2'(rot);
        cfg_tile = tile;
        cfg_base = base;
        cfg_bpp  = 3'(bpp);
    endtask

    // Driver: pushes expected items and sends pixels [first, last_excl)
    task automatic drive_span(int w, int h, int rot, bit tile, logic [31:0] base,
                              int bpp, int first, int stop, bit gaps);
        for (int i = first; i < stop; i++) begin
            int x, y;
            x = i % w;
            y = i / w;
            exp_q.push_back({(i == w * h - 1), model_addr(x, y, w, h, rot, tile, base, bpp)});
            exp_tag.push_back(32'(i));
            @(negedge clk);
            pix_valid = 1'b1;
            if (gaps && (i % 3 == 2)) begin
                @(negedge clk);
                pix_valid = 1'b0;
            end
        end
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic run_frame(int w, int h, int rot, bit tile, logic [31:0] base, int bpp, bit gaps);
        @(negedge clk);
        set_cfg(w, h, rot, tile, base, bpp);
        drive_span(w, h, rot, tile, base, bpp, 0, w * h, gaps);
        @(negedge clk);
        check(exp_q.size() == 0, "R2 all addresses issued", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(addr_valid == 1'b0, "R10 addr_valid after reset", addr_valid, 0);
        check(eof == 1'b0, "R10 eof after reset", eof, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(addr_valid == 1'b0, "R2 idle no address", addr_valid, 0);

        // R3/R4/R6: all rotations, linear, non-square
        run_frame(5, 3, 0, 1'b0, 32'h1000, 4, 1'b0);
        run_frame(5, 3, 1, 1'b0, 32'h2000, 2, 1'b1);
        run_frame(5, 3, 2, 1'b0, 32'h3000, 3, 1'b0);
        run_frame(5, 3, 3, 1'b0, 32'h4000, 4, 1'b1);
        // R5: tiled, multiple tiles, all rotations
        run_frame(16, 8, 0, 1'b1, 32'h8000, 4, 1'b0);
        run_frame(16, 8, 1, 1'b1, 32'h9000, 2, 1'b0);
        run_frame(8, 16, 2, 1'b1, 32'hA000, 3, 1'b1);
        run_frame(8, 16, 3, 1'b1, 32'hB000, 4, 1'b0);
        // R1/R9: boundary sizes
        run_frame(512, 1, 0, 1'b0, 32'h10000, 2, 1'b0);
        run_frame(1, 1, 1, 1'b0, 32'h20000, 4, 1'b0);
        run_frame(1, 4, 3, 1'b0, 32'h30000, 3, 1'b0);

        // R7: tiled width not multiple of 8
        @(negedge clk);
        set_cfg(12, 8, 0, 1'b1, 32'h0, 4);
        #1 check(cfg_err == 1'b1, "R7 tiled width 12", cfg_err, 1);
        set_cfg(16, 12, 0, 1'b1, 32'h0, 4);
        #1 check(cfg_err == 1'b1, "R7 tiled height 12", cfg_err, 1);
        set_cfg(12, 12, 0, 1'b0, 32'h0, 4);
        #1 check(cfg_err == 1'b0, "R7 linear 12x12 legal", cfg_err, 0);
        set_cfg(8, 8, 0, 1'b0, 32'h0, 5);
        #1 check(cfg_err == 1'b1, "R7 bpp 5", cfg_err, 1);
        set_cfg(8, 8, 0, 1'b0, 32'h0, 1);
        #1 check(cfg_err == 1'b1, "R7 bpp 1", cfg_err, 1);
        cfg_bpp = 3'd2; cfg_h_m1 = 10'd600;
        #1 check(cfg_err == 1'b1, "R7 height over 512", cfg_err, 1);

        // R8: break a frame with an illegal setup, then resume
        @(negedge clk);
        set_cfg(6, 4, 1, 1'b0, 32'h5000, 4);
        drive_span(6, 4, 1, 1'b0, 32'h5000, 4, 0, 7, 1'b0);
        @(negedge clk);
        cfg_bpp = 3'd7;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(addr_valid == 1'b0, "R8 no address during error", addr_valid, 0);
            pix_valid = 1'b1;
        end
        @(negedge clk);
        check(addr_valid == 1'b0, "R8 no address during error", addr_valid, 0);
        pix_valid = 1'b0;
        cfg_bpp = 3'd4;
        drive_span(6, 4, 1, 1'b0, 32'h5000, 4, 7, 24, 1'b1);
        @(negedge clk);
        check(exp_q.size() == 0, "R8 resumed frame complete", exp_q.size(), 0);

        // R1: next frame starts at origin again
        run_frame(3, 2, 2, 1'b0, 32'h6000, 2, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule